// File: doc/BRIEF.md
# Bidirectional Split-Mode LCD Common Scanner

This block is the logic core of a row (common) driver for a dot-matrix LCD panel. It holds a 120-stage scan register that advances by one stage on every falling edge of the shift clock. A direction input chooses which way the scan token travels. A split input turns the single chain into two independent 60-stage chains, and the second chain takes its data from a separate auxiliary serial input. Two cascade pins, each modelled as an input, an output and an output enable, pass scan data to and from neighbouring drivers. The roles of these pins follow the direction input at run time.

Each stage is turned into a 2-bit drive-level code from its register bit and an AC phase input. An active-low blanking input forces every output to the lowest selected level, and it does this without any clock, including while the block is held in reset. Several drivers are chained through the cascade pins to scan panels taller than one device. The split mode lets a single device serve the boundary between the two halves of a dual-scan panel.

Top module: `lcd_com_scanner`

## Requirements
- R1: An asynchronous low on `rst_n` clears all scan stages to 0. After `rst_n` rises, the first two falling clock edges do not shift, and shifting starts on the third.
- R2: With `dir_right`=1 and `split_mode`=0, each falling edge moves stage k to stage k+1 (0-based, stage 0 drives channel 0) and loads `casc_a_i` into stage 0.
- R3: With `dir_right`=0 and `split_mode`=0, each falling edge moves stage k+1 to stage k and loads `casc_b_i` into stage 119. Changing `dir_right` leaves the stored stages unchanged until the next edge.
- R4: When `dir_right`=1, `casc_b_oe`=1, `casc_a_oe`=0, `casc_b_o` equals stage 119 and `casc_a_o`=0. When `dir_right`=0 the roles are mirrored, and `casc_a_o` equals stage 0.
- R5: With `split_mode`=1 and `dir_right`=1, stage 60 loads `aux_in`. Stage 59 keeps shifting into no stage and its bit is lost. All other stages behave as in R2.
- R6: With `split_mode`=1 and `dir_right`=0, stage 59 loads `aux_in`. Stage 60 keeps shifting into no stage and its bit is lost. All other stages behave as in R3.
- R7: Channel k drives `level_code[2k+1:2k]`, coded as follows:
  - bit 1 with `ac_phase` 0 gives 00 (selected, positive);
  - bit 1 with `ac_phase` 1 gives 01 (selected, negative);
  - bit 0 with `ac_phase` 0 gives 10 (idle, low);
  - bit 0 with `ac_phase` 1 gives 11 (idle, high).
- R8: While `blank_n`=0, every channel code is 01 without any clock edge, in reset or not. Shifting continues underneath, and the stored content reappears when `blank_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shclk | input | 1 | Shift clock; the register advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_right | input | 1 | 1: scan from channel 0 upward; 0: scan downward |
| split_mode | input | 1 | 1: two 60-stage chains; 0: one 120-stage chain |
| aux_in | input | 1 | Serial input of the second chain in split mode |
| casc_a_i | input | 1 | Cascade pin A input (scan in when dir_right=1) |
| casc_a_o | output | 1 | Cascade pin A output data |
| casc_a_oe | output | 1 | Cascade pin A output enable |
| casc_b_i | input | 1 | Cascade pin B input (scan in when dir_right=0) |
| casc_b_o | output | 1 | Cascade pin B output data |
| casc_b_oe | output | 1 | Cascade pin B output enable |
| ac_phase | input | 1 | AC inversion phase |
| blank_n | input | 1 | Active-low display blanking |
| level_code | output | 240 | Two-bit drive-level code per channel, channel k at bits 2k+1:2k |

## Verification
Blanking and shifting can fall in the same clock cycle. The bench clocks scan data through the register while `blank_n` is low, checks the all-01 bus after every edge, and then raises `blank_n` and compares the bus against its own register model. A change of direction or split mode can also meet a shift edge. Those controls are changed between edges in the middle of a scan. The bus is compared once before the next edge, to confirm that nothing moved, and again after the edges that follow, against the model using the new routing.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;

  // Drive-level codes presented per channel
  typedef enum logic [1:0] {
    LVL_SEL_POS  = 2'b00,
    LVL_SEL_NEG  = 2'b01,
    LVL_IDLE_LOW = 2'b10,
    LVL_IDLE_HI  = 2'b11
  } drive_lvl_e;

  localparam int unsigned CODE_W = 2;

  // Level selection for one channel; blanking wins over everything
  function automatic drive_lvl_e pick_level(input logic row_bit,
                                            input logic ac,
                                            input logic blank_n);
    drive_lvl_e lvl;
    if (!blank_n) begin
      lvl = LVL_SEL_NEG;
    end else begin
      unique case ({ac, row_bit})
        2'b01:   lvl = LVL_SEL_POS;
        2'b11:   lvl = LVL_SEL_NEG;
        2'b00:   lvl = LVL_IDLE_LOW;
        default: lvl = LVL_IDLE_HI;
      endcase
    end
    return lvl;
  endfunction

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_n_edge,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(negedge clk_n_edge or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/lcd_shift_core.sv
module lcd_shift_core #(
  parameter int unsigned N_CH = 120
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            dir_right,
  input  logic            split_mode,
  input  logic            ser_a,
  input  logic            ser_b,
  input  logic            ser_aux,
  output logic [N_CH-1:0] sr_q
);
  localparam int unsigned HALF = N_CH / 2;

  logic [N_CH-1:0] sr_d;

  // Next-state per stage: source when moving up, source when moving down
  for (genvar k = 0; k < N_CH; k++) begin : g_stage
    logic up_src;
    logic dn_src;

    if (k == 0) begin : g_up_head
      assign up_src = ser_a;
    end else if (k == HALF) begin : g_up_split
      assign up_src = split_mode ? ser_aux : sr_q[k-1];
    end else begin : g_up_body
      assign up_src = sr_q[k-1];
    end

    if (k == N_CH - 1) begin : g_dn_head
      assign dn_src = ser_b;
    end else if (k == HALF - 1) begin : g_dn_split
      assign dn_src = split_mode ? ser_aux : sr_q[k+1];
    end else begin : g_dn_body
      assign dn_src = sr_q[k+1];
    end

    assign sr_d[k] = dir_right ? up_src : dn_src;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= sr_d;
    end
  end
endmodule

// File: rtl/lcd_cascade_io.sv
module lcd_cascade_io (
  input  logic dir_right,
  input  logic stage_first,
  input  logic stage_last,
  output logic a_o,
  output logic a_oe,
  output logic b_o,
  output logic b_oe
);
  always_comb begin
    a_oe = !dir_right;
    b_oe = dir_right;
    a_o  = a_oe ? stage_first : 1'b0;
    b_o  = b_oe ? stage_last  : 1'b0;
  end
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_com_pkg::*;
#(
  parameter int unsigned N_CH = 120
) (
  input  logic                   ac_phase,
  input  logic                   blank_n,
  input  logic [N_CH-1:0]        row_bits,
  output logic [CODE_W*N_CH-1:0] codes
);
  for (genvar k = 0; k < N_CH; k++) begin : g_chan
    drive_lvl_e lvl;
    always_comb begin
      lvl = pick_level(row_bits[k], ac_phase, blank_n);
    end
    assign codes[CODE_W*k +: CODE_W] = lvl;
  end
endmodule

// File: rtl/lcd_com_scanner.sv
module lcd_com_scanner #(
  parameter int unsigned N_CH = 120
) (
  input  logic              shclk,
  input  logic              rst_n,
  input  logic              dir_right,
  input  logic              split_mode,
  input  logic              aux_in,
  input  logic              casc_a_i,
  output logic              casc_a_o,
  output logic              casc_a_oe,
  input  logic              casc_b_i,
  output logic              casc_b_o,
  output logic              casc_b_oe,
  input  logic              ac_phase,
  input  logic              blank_n,
  output logic [2*N_CH-1:0] level_code
);
  logic            run_q;
  logic [N_CH-1:0] sr_q;

  lcd_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_n_edge (shclk),
    .rst_n      (rst_n),
    .run        (run_q)
  );

  lcd_shift_core #(.N_CH(N_CH)) u_core (
    .clk        (shclk),
    .rst_n      (rst_n),
    .shift_en   (run_q),
    .dir_right  (dir_right),
    .split_mode (split_mode),
    .ser_a      (casc_a_i),
    .ser_b      (casc_b_i),
    .ser_aux    (aux_in),
    .sr_q       (sr_q)
  );

  lcd_cascade_io u_casc (
    .dir_right   (dir_right),
    .stage_first (sr_q[0]),
    .stage_last  (sr_q[N_CH-1]),
    .a_o         (casc_a_o),
    .a_oe        (casc_a_oe),
    .b_o         (casc_b_o),
    .b_oe        (casc_b_oe)
  );

  lcd_level_enc #(.N_CH(N_CH)) u_enc (
    .ac_phase (ac_phase),
    .blank_n  (blank_n),
    .row_bits (sr_q),
    .codes    (level_code)
  );
endmodule

// File: rtl/lcd_com_scanner_chk.sv
module lcd_com_scanner_chk #(
  parameter int unsigned N_CH = 120
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              dir_right,
  input logic              split_mode,
  input logic              aux_in,
  input logic              casc_a_i,
  input logic              casc_a_o,
  input logic              casc_a_oe,
  input logic              casc_b_i,
  input logic              casc_b_o,
  input logic              casc_b_oe,
  input logic              ac_phase,
  input logic              blank_n,
  input logic [N_CH-1:0]   sr_q,
  input logic [2*N_CH-1:0] level_code
);
  localparam int unsigned HALF = N_CH / 2;

  assert_hold_zero_R1: assert property (@(negedge clk) disable iff (!rst_n)
    !run |-> (sr_q == '0));

  assert_up_entry_R2: assert property (@(negedge clk) disable iff (!rst_n)
    run && dir_right |=> sr_q[0] == $past(casc_a_i));

  assert_up_body_R2: assert property (@(negedge clk) disable iff (!rst_n)
    run && dir_right && !split_mode |=> sr_q[N_CH-1:1] == $past(sr_q[N_CH-2:0]));

  assert_dn_entry_R3: assert property (@(negedge clk) disable iff (!rst_n)
    run && !dir_right |=> sr_q[N_CH-1] == $past(casc_b_i));

  assert_dn_body_R3: assert property (@(negedge clk) disable iff (!rst_n)
    run && !dir_right && !split_mode |=> sr_q[N_CH-2:0] == $past(sr_q[N_CH-1:1]));

  assert_pin_b_out_R4: assert property (@(negedge clk) disable iff (!rst_n)
    dir_right |-> casc_b_oe && !casc_a_oe && (casc_b_o == sr_q[N_CH-1]) && !casc_a_o);

  assert_pin_a_out_R4: assert property (@(negedge clk) disable iff (!rst_n)
    !dir_right |-> casc_a_oe && !casc_b_oe && (casc_a_o == sr_q[0]) && !casc_b_o);

  assert_split_up_R5: assert property (@(negedge clk) disable iff (!rst_n)
    run && dir_right && split_mode |=> sr_q[HALF] == $past(aux_in));

  assert_split_dn_R6: assert property (@(negedge clk) disable iff (!rst_n)
    run && !dir_right && split_mode |=> sr_q[HALF-1] == $past(aux_in));

  assert_sel_pos_R7: assert property (@(negedge clk) disable iff (!rst_n)
    blank_n && !ac_phase && sr_q[0] |-> level_code[1:0] == 2'b00);

  assert_idle_hi_R7: assert property (@(negedge clk) disable iff (!rst_n)
    blank_n && ac_phase && !sr_q[N_CH-1] |-> level_code[2*N_CH-1:2*N_CH-2] == 2'b11);

  assert_blank_R8: assert property (@(negedge clk) disable iff (!rst_n)
    !blank_n |-> level_code == {N_CH{2'b01}});
endmodule

bind lcd_com_scanner lcd_com_scanner_chk #(.N_CH(N_CH)) u_chk (
  .clk        (shclk),
  .rst_n      (rst_n),
  .run        (run_q),
  .dir_right  (dir_right),
  .split_mode (split_mode),
  .aux_in     (aux_in),
  .casc_a_i   (casc_a_i),
  .casc_a_o   (casc_a_o),
  .casc_a_oe  (casc_a_oe),
  .casc_b_i   (casc_b_i),
  .casc_b_o   (casc_b_o),
  .casc_b_oe  (casc_b_oe),
  .ac_phase   (ac_phase),
  .blank_n    (blank_n),
  .sr_q       (sr_q),
  .level_code (level_code)
);

// File: tb/lcd_com_scanner_bench.sv
module lcd_com_scanner_bench;
  localparam int N = 120;
  localparam int H = N / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, dir_right = 1'b1, split_mode = 1'b0, aux_in = 1'b0;
  logic casc_a_i = 1'b0, casc_b_i = 1'b0, ac_phase = 1'b0, blank_n = 1'b1;
  logic casc_a_o, casc_a_oe, casc_b_o, casc_b_oe;
  logic [2*N-1:0] level_code;

  lcd_com_scanner #(.N_CH(N)) u_lcd_com_scanner (
    .shclk(clk), .rst_n(rst_n), .dir_right(dir_right), .split_mode(split_mode),
    .aux_in(aux_in), .casc_a_i(casc_a_i), .casc_a_o(casc_a_o), .casc_a_oe(casc_a_oe),
    .casc_b_i(casc_b_i), .casc_b_o(casc_b_o), .casc_b_oe(casc_b_oe),
    .ac_phase(ac_phase), .blank_n(blank_n), .level_code(level_code)
  );

  int total = 0;
  int bad = 0;
  logic [N-1:0] exp_sr = '0;

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R7/R8 code table
  function automatic logic [1:0] exp_code(input logic b);
    if (!blank_n) return 2'b01;
    case ({ac_phase, b})
      2'b01:   return 2'b00;
      2'b11:   return 2'b01;
      2'b00:   return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [2*N-1:0] exp_bus();
    logic [2*N-1:0] v;
    for (int k = 0; k < N; k++) v[2*k +: 2] = exp_code(exp_sr[k]);
    return v;
  endfunction

  function automatic logic pat(input int i, input int s);
    return ((i * s + i / 3) % 4) < 2;
  endfunction

  task automatic check_bus(input string req, input string what);
    chk(req, what, {16'h0, level_code}, {16'h0, exp_bus()});
  endtask

  task automatic check_pins(input string req);
    chk(req, "pin outputs", {252'h0, casc_a_oe, casc_a_o, casc_b_oe, casc_b_o},
        {252'h0, !dir_right, dir_right ? 1'b0 : exp_sr[0],
         dir_right, dir_right ? exp_sr[N-1] : 1'b0});
  endtask

  // One falling edge; model follows R2/R3/R5/R6
  task automatic step(input logic a, input logic b, input logic x);
    logic [N-1:0] o;
    casc_a_i = a; casc_b_i = b; aux_in = x;
    @(negedge clk);
    o = exp_sr;
    if (dir_right) begin
      exp_sr = {o[N-2:0], a};
      if (split_mode) exp_sr[H] = x;
    end else begin
      exp_sr = {b, o[N-1:1]};
      if (split_mode) exp_sr[H-1] = x;
    end
    #2;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "bus in reset", {16'h0, level_code}, {16'h0, {N{2'b10}}});
    blank_n = 1'b0; #1;
    chk("R8", "blank in reset", {16'h0, level_code}, {16'h0, {N{2'b01}}});
    blank_n = 1'b1;
    @(posedge clk); #1 rst_n = 1'b1;
    for (int e = 0; e < 2; e++) begin
      casc_a_i = 1'b1;
      @(negedge clk); #2;
      chk("R1", "no shift during release", {254'h0, level_code[1:0]}, {254'h0, 2'b10});
    end
    casc_a_i = 1'b0;
    @(negedge clk); #2;
    check_bus("R1", "bus after release");
  endtask

  task automatic t_right();
    dir_right = 1'b1; split_mode = 1'b0; ac_phase = 1'b1;
    for (int i = 0; i < 130; i++) begin
      step(pat(i, 5), 1'b0, 1'b1);
      check_pins("R4");
      if (i == 40) check_bus("R2", "bus mid scan up");
    end
    check_bus("R2", "bus after scan up");
  endtask

  task automatic t_left();
    dir_right = 1'b0; #1;
    check_bus("R3", "contents kept across direction swap");
    check_pins("R4");
    for (int i = 0; i < 47; i++) begin
      step(1'b1, pat(i, 7), 1'b0);
      check_pins("R4");
    end
    check_bus("R3", "bus after scan down");
  endtask

  task automatic t_split_right();
    dir_right = 1'b1; split_mode = 1'b1; ac_phase = 1'b0;
    for (int i = 0; i < 75; i++) begin
      step(pat(i, 3), 1'b1, pat(i + 1, 11));
      check_pins("R4");
    end
    check_bus("R5", "bus after split up");
  endtask

  task automatic t_split_left();
    dir_right = 1'b0; split_mode = 1'b1; ac_phase = 1'b1;
    for (int i = 0; i < 75; i++) begin
      step(1'b0, pat(i, 9), pat(i + 2, 13));
      check_pins("R4");
    end
    check_bus("R6", "bus after split down");
  endtask

  task automatic t_levels();
    dir_right = 1'b1; split_mode = 1'b0;
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    ac_phase = 1'b0; #1;
    chk("R7", "codes ac=0", {252'h0, level_code[3:0]}, {252'h0, 4'b1000});
    check_bus("R7", "bus ac=0");
    ac_phase = 1'b1; #1;
    chk("R7", "codes ac=1", {252'h0, level_code[3:0]}, {252'h0, 4'b1101});
    check_bus("R7", "bus ac=1");
  endtask

  task automatic t_blank();
    blank_n = 1'b0; ac_phase = 1'b0; #1;
    chk("R8", "blank ac=0", {16'h0, level_code}, {16'h0, {N{2'b01}}});
    ac_phase = 1'b1; #1;
    chk("R8", "blank ac=1", {16'h0, level_code}, {16'h0, {N{2'b01}}});
    for (int i = 0; i < 5; i++) begin
      step(pat(i, 2), 1'b0, 1'b0);
      chk("R8", "blank while shifting", {16'h0, level_code}, {16'h0, {N{2'b01}}});
    end
    blank_n = 1'b1; #1;
    check_bus("R8", "content restored after blank");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_right();
    t_left();
    t_split_right();
    t_split_left();
    t_levels();
    t_blank();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule